// File: doc/BRIEF.md
# Latched Event Status Register Set

This block collects the status of a programmable instrument. It has two paths. The first is an 8-bit standard event path. One-cycle event pulses from the surrounding logic set sticky bits, and an enable mask reduces those bits to a single event-summary flag. The second is a 16-bit operation path. Live condition levels pass through an edge filter, which latches selected rising or falling changes into a sticky event register. That register has its own enable mask and summary flag.

A flat register port takes the place of the status commands. A read of either event register returns its content and clears it in the same access. The enable, condition and filter registers keep their values when read. A one-cycle clear-status strobe empties both event registers. The two summary outputs feed the logic that builds the service request.

Top module: `evt_status_unit`

## Requirements
- R1: A high bit on `std_evt_i` for one cycle sets the matching standard event bit at the next clock edge. The bit stays set after the input returns low, until a clear.
- R2: A read at address 0 returns the standard event register as it was before the access, and clears it at the end of the access.
- R3: `esb_o` is the OR over all bits of (standard event AND standard enable). It is registered, so it follows a change in the event register one cycle later. An enable bit of 0 masks its event.
- R4: The standard enable register (address 1) holds its value through any number of reads. It is cleared only by reset or by a write of 0.
- R5: A pulse on `oq_rd_i` while `oq_empty_i` is high sets standard event bit 2 (query error). The same pulse with `oq_empty_i` low sets nothing.
- R6: The operation condition register (address 2, read-only) samples `op_cond_i` every cycle. Bit 5 is taken from `wait_trig_i` and bit 6 from `wait_arm_i`. A write to address 2 is ignored.
- R7: A 0-to-1 change of a condition bit sets the matching operation event bit only when that bit is set in the positive filter (address 5).
- R8: A 1-to-0 change sets the bit only when that bit is set in the negative filter (address 6). With both filter bits clear, no change latches.
- R9: A read at address 3 returns the operation event register and clears it. `op_sum_o` is the registered OR of (operation event AND operation enable, address 4).
- R10: An event that arrives in the cycle an event register is cleared, by read or by `cls_i`, is present in that register after the clear.
- R11: `cls_i` clears both event registers. It leaves both enable registers and both filter registers unchanged.
- R12: Reads at address 7 return 0. After reset, every register and both summary outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| std_evt_i | input | 8 | Standard event pulses, one bit per event |
| oq_rd_i | input | 1 | Read attempt on the output queue |
| oq_empty_i | input | 1 | Output queue is empty |
| op_cond_i | input | 16 | Live operation condition levels (bits 5 and 6 replaced) |
| wait_trig_i | input | 1 | Level: waiting in the trigger layer (condition bit 5) |
| wait_arm_i | input | 1 | Level: waiting in an arm layer (condition bit 6) |
| cls_i | input | 1 | Clear-status strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears event registers) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, combinational from address and state |
| esb_o | output | 1 | Standard event summary |
| op_sum_o | output | 1 | Operation event summary |

## Verification
The hardest case to reach is an event that lands in the very cycle its register is cleared by a read. The bench raises a standard event pulse in the same cycle as the read strobe. It then checks two things: the read data shows only the older bit, and a second read shows only the new bit. The operation filter cases need the condition history in a known state. The bench therefore steps the condition inputs through a planned sequence of rises and falls, and reprograms the filter masks between steps.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;
  localparam int STD_W         = 8;
  localparam int OP_W          = 16;
  localparam int ADDR_W        = 3;
  localparam int QERR_BIT      = 2;
  localparam int WAIT_TRIG_BIT = 5;
  localparam int WAIT_ARM_BIT  = 6;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_STD_EVT = 3'd0,
    ADDR_STD_ENA = 3'd1,
    ADDR_OP_COND = 3'd2,
    ADDR_OP_EVT  = 3'd3,
    ADDR_OP_ENA  = 3'd4,
    ADDR_OP_PTR  = 3'd5,
    ADDR_OP_NTR  = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/latched_evt_reg.sv
module latched_evt_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  input  logic         en_we_i,
  input  logic [W-1:0] en_wdata_i,
  output logic [W-1:0] evt_o,
  output logic [W-1:0] en_o,
  output logic         sum_o
);
  logic [W-1:0] evt_q, en_q;
  logic         sum_q;

  // set dominates clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= (clr_i ? '0 : evt_q) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= en_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= 1'b0;
    else         sum_q <= |(evt_q & en_q);
  end

  assign evt_o = evt_q;
  assign en_o  = en_q;
  assign sum_o = sum_q;

  AST_EVT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((evt_q & $past(evt_q)) == $past(evt_q))); // R1
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((evt_q & $past(set_i)) == $past(set_i))); // R10
  AST_SUM_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sum_o == |($past(evt_o) & $past(en_o)))); // R3
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_we_i |=> $stable(en_q)); // R4
endmodule

// File: rtl/op_trans_filter.sv
module op_trans_filter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_i,
  input  logic         ptr_we_i,
  input  logic         ntr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cond_o,
  output logic [W-1:0] ptr_o,
  output logic [W-1:0] ntr_o,
  output logic [W-1:0] set_o
);
  logic [W-1:0] cond_q, ptr_q, ntr_q;
  logic [W-1:0] rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cond_q <= '0;
    else         cond_q <= cond_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      ntr_q <= '0;
    end else begin
      if (ptr_we_i) ptr_q <= wdata_i;
      if (ntr_we_i) ntr_q <= wdata_i;
    end
  end

  // edge seen at the same edge that updates cond_q
  assign rise   = cond_i & ~cond_q;
  assign fall   = ~cond_i & cond_q;
  assign set_o  = (rise & ptr_q) | (fall & ntr_q);
  assign cond_o = cond_q;
  assign ptr_o  = ptr_q;
  assign ntr_o  = ntr_q;

  AST_SET_ONLY_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_o & ~(cond_i ^ cond_o)) == '0); // R7
  AST_SET_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_o & ~(ptr_o | ntr_o)) == '0); // R8
  AST_FILTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ptr_we_i || ntr_we_i) |=> ($stable(ptr_q) && $stable(ntr_q))); // R11
endmodule

// File: rtl/evt_status_unit.sv
module evt_status_unit
  import evt_status_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STD_W-1:0]  std_evt_i,
  input  logic              oq_rd_i,
  input  logic              oq_empty_i,
  input  logic [OP_W-1:0]   op_cond_i,
  input  logic              wait_trig_i,
  input  logic              wait_arm_i,
  input  logic              cls_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [OP_W-1:0]   reg_wdata_i,
  output logic [OP_W-1:0]   reg_rdata_o,
  output logic              esb_o,
  output logic              op_sum_o
);
  localparam int PAD_W = OP_W - STD_W;

  logic [STD_W-1:0] std_set, std_evt, std_en;
  logic [OP_W-1:0]  op_cond_in, op_cond, op_set, op_evt, op_en, op_ptr, op_ntr;
  logic             std_clr, op_clr, std_rd, op_rd;

  always_comb begin
    std_set           = std_evt_i;
    std_set[QERR_BIT] = std_evt_i[QERR_BIT] | (oq_rd_i & oq_empty_i);
  end

  always_comb begin
    op_cond_in                = op_cond_i;
    op_cond_in[WAIT_TRIG_BIT] = wait_trig_i;
    op_cond_in[WAIT_ARM_BIT]  = wait_arm_i;
  end

  assign std_rd  = reg_rd_i && (reg_addr_i == ADDR_STD_EVT);
  assign op_rd   = reg_rd_i && (reg_addr_i == ADDR_OP_EVT);
  assign std_clr = std_rd | cls_i;
  assign op_clr  = op_rd | cls_i;

  latched_evt_reg #(.W(STD_W)) u_std (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (std_set),
    .clr_i      (std_clr),
    .en_we_i    (reg_wr_i && (reg_addr_i == ADDR_STD_ENA)),
    .en_wdata_i (reg_wdata_i[STD_W-1:0]),
    .evt_o      (std_evt),
    .en_o       (std_en),
    .sum_o      (esb_o)
  );

  op_trans_filter #(.W(OP_W)) u_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cond_i   (op_cond_in),
    .ptr_we_i (reg_wr_i && (reg_addr_i == ADDR_OP_PTR)),
    .ntr_we_i (reg_wr_i && (reg_addr_i == ADDR_OP_NTR)),
    .wdata_i  (reg_wdata_i),
    .cond_o   (op_cond),
    .ptr_o    (op_ptr),
    .ntr_o    (op_ntr),
    .set_o    (op_set)
  );

  latched_evt_reg #(.W(OP_W)) u_op (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (op_set),
    .clr_i      (op_clr),
    .en_we_i    (reg_wr_i && (reg_addr_i == ADDR_OP_ENA)),
    .en_wdata_i (reg_wdata_i),
    .evt_o      (op_evt),
    .en_o       (op_en),
    .sum_o      (op_sum_o)
  );

  always_comb begin
    case (reg_addr_i)
      ADDR_STD_EVT: reg_rdata_o = {{PAD_W{1'b0}}, std_evt};
      ADDR_STD_ENA: reg_rdata_o = {{PAD_W{1'b0}}, std_en};
      ADDR_OP_COND: reg_rdata_o = op_cond;
      ADDR_OP_EVT:  reg_rdata_o = op_evt;
      ADDR_OP_ENA:  reg_rdata_o = op_en;
      ADDR_OP_PTR:  reg_rdata_o = op_ptr;
      ADDR_OP_NTR:  reg_rdata_o = op_ntr;
      default:      reg_rdata_o = '0;
    endcase
  end

  AST_STD_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (std_rd && std_set == '0) |=> (std_evt == '0)); // R2
  AST_CLS_CLEARS_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_i && op_set == '0) |=> (op_evt == '0)); // R11
  AST_QERR_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oq_rd_i && oq_empty_i) |=> std_evt[QERR_BIT]); // R5
  AST_COND_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (op_cond[WAIT_TRIG_BIT] == $past(wait_trig_i) &&
              op_cond[WAIT_ARM_BIT] == $past(wait_arm_i))); // R6
endmodule

// File: tb/evt_status_unit_tb_top.sv
module evt_status_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {enable, event pulse, expected summary}
  localparam logic [16:0] VEC [NVEC] = '{
    {8'h01, 8'h01, 1'b1},
    {8'h01, 8'h02, 1'b0},
    {8'h80, 8'h80, 1'b1},
    {8'h00, 8'hFF, 1'b0},
    {8'hF0, 8'h18, 1'b1},
    {8'h0F, 8'hF0, 1'b0}
  };

  logic        clk = 0, rst_n = 0;
  logic [7:0]  std_evt = 0;
  logic        oq_rd = 0, oq_empty = 0, wait_trig = 0, wait_arm = 0, cls = 0;
  logic [15:0] op_cond = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0, rdata;
  logic        esb, op_sum;
  int          n_chk = 0, n_fail = 0;
  logic [15:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_status_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .std_evt_i(std_evt), .oq_rd_i(oq_rd),
    .oq_empty_i(oq_empty), .op_cond_i(op_cond), .wait_trig_i(wait_trig),
    .wait_arm_i(wait_arm), .cls_i(cls), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata),
    .esb_o(esb), .op_sum_o(op_sum)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_rd = 1; reg_addr = a;
    #1 d = rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic pulse(input logic [7:0] e);
    std_evt = e;
    @(negedge clk);
    std_evt = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    // R12 reset state
    chk("R12 esb reset", {15'd0, esb}, 16'd0);
    chk("R12 op_sum reset", {15'd0, op_sum}, 16'd0);
    rd(3'd1, v); chk("R12 enable reset", v, 16'h0000);
    rd(3'd0, v); chk("R12 event reset", v, 16'h0000);

    // R3 vector table
    for (int i = 0; i < NVEC; i++) begin
      wr(3'd1, {8'h00, VEC[i][16:9]});
      pulse(VEC[i][8:1]);
      tick();
      chk("R3 esb set", {15'd0, esb}, {15'd0, VEC[i][0]});
      rd(3'd0, v); chk("R2 read value", v, {8'h00, VEC[i][8:1]});
      tick();
      chk("R3 esb after clear", {15'd0, esb}, 16'd0);
    end

    // R1 stickiness
    pulse(8'h01); tick(); tick(); tick();
    rd(3'd0, v); chk("R1 sticky", v, 16'h0001);
    rd(3'd0, v); chk("R2 cleared by read", v, 16'h0000);

    // R2 clear by cls
    pulse(8'h10);
    cls = 1; tick(); cls = 0;
    rd(3'd0, v); chk("R2 cls clears", v, 16'h0000);

    // R4 enable read does not clear; write 0 clears
    wr(3'd1, 16'h00A5);
    rd(3'd1, v); chk("R4 enable read1", v, 16'h00A5);
    rd(3'd1, v); chk("R4 enable read2", v, 16'h00A5);
    wr(3'd1, 16'h0000);
    rd(3'd1, v); chk("R4 write zero", v, 16'h0000);

    // R5 query error
    oq_rd = 1; oq_empty = 1; tick(); oq_rd = 0; oq_empty = 0;
    rd(3'd0, v); chk("R5 query error", v, 16'h0004);
    oq_rd = 1; tick(); oq_rd = 0;
    rd(3'd0, v); chk("R5 non-empty read", v, 16'h0000);

    // R10 event concurrent with read-clear
    pulse(8'h01);
    reg_rd = 1; reg_addr = 3'd0; std_evt = 8'h08;
    #1 v = rdata;
    @(negedge clk);
    reg_rd = 0; std_evt = 0;
    chk("R10 pre-clear value", v, 16'h0001);
    rd(3'd0, v); chk("R10 event survives", v, 16'h0008);

    // R6 condition register, masks clear
    op_cond = 16'h8001; wait_trig = 1; wait_arm = 0; tick();
    rd(3'd2, v); chk("R6 condition", v, 16'h8021);
    wait_arm = 1; tick();
    rd(3'd2, v); chk("R6 arm bit", v, 16'h8061);
    wr(3'd2, 16'h0000);
    rd(3'd2, v); chk("R6 write ignored", v, 16'h8061);
    op_cond = 16'h0000; wait_trig = 0; wait_arm = 0; tick();
    rd(3'd3, v); chk("R8 no mask no latch", v, 16'h0000);

    // R7 / R8 transition filter
    wr(3'd5, 16'h0021);
    wr(3'd6, 16'h8000);
    op_cond = 16'h0001; wait_trig = 1; tick();
    op_cond = 16'h8001; tick();
    rd(3'd3, v); chk("R7 rising latch", v, 16'h0021);
    op_cond = 16'h0001; tick();
    op_cond = 16'h0000; tick();
    rd(3'd3, v); chk("R8 falling latch", v, 16'h8000);

    // R9 operation summary
    wr(3'd4, 16'h8000);
    wr(3'd5, 16'h8000);
    op_cond = 16'h8000; tick(); tick();
    chk("R9 op_sum set", {15'd0, op_sum}, 16'd1);
    rd(3'd3, v); chk("R9 read value", v, 16'h8000);
    chk("R9 op_sum lag", {15'd0, op_sum}, 16'd1);
    tick();
    chk("R9 op_sum cleared", {15'd0, op_sum}, 16'd0);
    rd(3'd3, v); chk("R9 cleared by read", v, 16'h0000);

    // R11 cls clears both, keeps enables and filters
    wr(3'd1, 16'h0001);
    pulse(8'h01);
    op_cond = 16'h0000; tick();
    cls = 1; tick(); cls = 0;
    rd(3'd0, v); chk("R11 std cleared", v, 16'h0000);
    rd(3'd3, v); chk("R11 op cleared", v, 16'h0000);
    rd(3'd1, v); chk("R11 std enable kept", v, 16'h0001);
    rd(3'd4, v); chk("R11 op enable kept", v, 16'h8000);
    rd(3'd5, v); chk("R11 ptr kept", v, 16'h8000);
    rd(3'd6, v); chk("R11 ntr kept", v, 16'h8000);

    // R12 unmapped address, reset clears enable
    rd(3'd7, v); chk("R12 unmapped", v, 16'h0000);
    rst_n = 0; tick(); rst_n = 1; tick();
    rd(3'd1, v); chk("R4 reset clears enable", v, 16'h0000);
    rd(3'd5, v); chk("R12 reset clears ptr", v, 16'h0000);

    finish_run();
  end
endmodule